// File: doc/BRIEF.md
# Clock Rate Change Sequencer

This block takes a requested core clock frequency in MHz, looks it up in a fixed on-chip table of nineteen supported rates and, when the rate matches exactly, reprograms a PLL through a simple register-write master port. After the control word is written it waits a fixed lock interval. It then samples the PLL lock and error flags and returns one of four result codes.

A companion divider generates the interface clock from the core clock, and the block manages it as well. When the new rate is above the threshold, the divider is set to halve before the PLL changes. It is returned to pass-through only once the PLL has relocked cleanly at a rate at or below the threshold. This way the interface clock never runs too fast during a change. A query mode scans the same table and returns the supported rate nearest to any request, without writing anything. A parameter removes the divider handling for PLLs that have no companion divider.

Top module: `clk_rate_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_wr` are low.
- R2: For a set request whose rate is above THRESH_MHZ (500), the divider register receives code 0x1 (halve) before the PLL control word is written.
- R3: The control word has bit 0 (power-down) and bit 1 (bypass) cleared. The output divider field is in [3:2], the input divider field in [8:4], the feedback field in [15:9] and the band field in [23:20]. Entries: 100 MHz = (in 0, fb 11, out 3); 500 MHz = (0, 14, 1); 600 MHz = (0, 17, 1); 1000 MHz = (1, 29, 0); band is 0 throughout.
- R4: The result is decided no earlier than CLK_MHZ*LOCK_US cycles after the control word write. Lock low gives status 1 (timeout). Lock high with the error flag set gives status 2 (error). Otherwise the status is 0 (ok).
- R5: Code 0x0 (pass-through) is written to the divider only after a clean relock at a rate at or below 500 MHz. No divider write follows a timeout or an error.
- R6: A set request whose rate does not exactly equal a table entry completes with status 3 and produces no bus write.
- R7: A query returns, on `resp_mhz` with status 0, the table rate nearest to the request. On a tie the lower-indexed (earlier) entry wins. A query produces no bus write.
- R8: `busy` is high from acceptance until completion, and a `req_valid` raised while busy is ignored.
- R9: `done` is a single-cycle pulse, and `status` is valid while it is high.
- R10: With HAS_IF_DIV = 0, no write to the divider address ever occurs.
- R11: The table holds, in order: 100, 133, 200, 233, 300, 333, 400, 500, 600, 700, 800 MHz, then 900 to 1600 MHz in 100 MHz steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_query | input | 1 | 1 = nearest-rate query, 0 = set rate |
| req_mhz | input | 16 | Requested rate in MHz |
| pll_locked | input | 1 | PLL lock flag |
| pll_err | input | 1 | PLL error flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 error, 3 invalid rate |
| resp_mhz | output | 16 | Nearest table rate (query result) |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | ADDR_W | Register write address |
| bus_wdata | output | 32 | Register write data |

## Verification
The bench targets the ordering of the divider writes around the control word. A design that swapped them would let the interface clock overrun. A design that restored pass-through after a timeout or an error would show an extra divider write in the scoreboard. The exact 500 MHz boundary, tie-breaking at 550 MHz and out-of-range queries at both ends of the table catch off-by-one comparisons. A request injected while busy, and a rate missing from the table, expose designs that accept overlapping requests or touch registers on a rejected rate.

// File: rtl/clk_rate_seq_pkg.sv
package clk_rate_seq_pkg;

  localparam int N_RATES = 19;
  localparam int MHZ_W   = 16;
  localparam int IDX_W   = $clog2(N_RATES);

  typedef struct packed {
    logic [MHZ_W-1:0] mhz;
    logic [4:0]       in_div;
    logic [6:0]       fb_div;
    logic [1:0]       out_div;
    logic [3:0]       band;
  } rate_entry_t;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_ERROR   = 2'd2,
    RES_BADRATE = 2'd3
  } result_t;

  function automatic rate_entry_t make_entry(input int m, input int i, input int f, input int o);
    rate_entry_t e;
    e.mhz     = MHZ_W'(m);
    e.in_div  = 5'(i);
    e.fb_div  = 7'(f);
    e.out_div = 2'(o);
    e.band    = 4'd0;
    return e;
  endfunction

  // Entries 11..18 follow a regular 100 MHz ladder and are computed.
  function automatic rate_entry_t rate_lookup(input logic [IDX_W-1:0] idx);
    case (idx)
      5'd0:  return make_entry(100, 0, 11, 3);
      5'd1:  return make_entry(133, 0, 15, 3);
      5'd2:  return make_entry(200, 1, 47, 3);
      5'd3:  return make_entry(233, 1, 27, 2);
      5'd4:  return make_entry(300, 1, 35, 2);
      5'd5:  return make_entry(333, 1, 39, 2);
      5'd6:  return make_entry(400, 1, 47, 2);
      5'd7:  return make_entry(500, 0, 14, 1);
      5'd8:  return make_entry(600, 0, 17, 1);
      5'd9:  return make_entry(700, 0, 20, 1);
      5'd10: return make_entry(800, 0, 23, 1);
      default: begin
        int k;
        k = int'(idx) - 11;
        if (k < 0 || k > 7) k = 7;
        return make_entry(900 + 100 * k, 1, 26 + 3 * k, 0);
      end
    endcase
  endfunction

  // Field layout is fixed by the PLL that decodes it.
  function automatic logic [31:0] pack_ctrl(input rate_entry_t e);
    logic [31:0] w;
    w        = '0;
    w[3:2]   = e.out_div;
    w[8:4]   = e.in_div;
    w[15:9]  = e.fb_div;
    w[23:20] = e.band;
    return w;
  endfunction

  function automatic logic [MHZ_W-1:0] abs_diff(input logic [MHZ_W-1:0] a, input logic [MHZ_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/clk_rate_rom.sv
module clk_rate_rom
  import clk_rate_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output rate_entry_t      entry
);
  always_comb entry = rate_lookup(idx);
endmodule

// File: rtl/clk_lock_timer.sv
module clk_lock_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

  logic [CNT_W-1:0] cnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= CNT_W'(CYCLES - 1);
      end else if (running) begin
        if (cnt == '0) begin
          running <= 1'b0;
          fire    <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clk_rate_seq.sv
module clk_rate_seq
  import clk_rate_seq_pkg::*;
#(
  parameter int                CLK_MHZ    = 100,
  parameter int                LOCK_US    = 100,
  parameter int                THRESH_MHZ = 500,
  parameter int                HAS_IF_DIV = 1,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] DIV_ADDR   = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_query,
  input  logic [15:0]       req_mhz,
  input  logic              pll_locked,
  input  logic              pll_err,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [15:0]       resp_mhz,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata
);
  localparam int   LOCK_CYCLES = CLK_MHZ * LOCK_US;
  localparam bit   DIV_EN      = (HAS_IF_DIV != 0);
  localparam logic [MHZ_W-1:0] THRESH = MHZ_W'(THRESH_MHZ);
  localparam logic [31:0] DIV_HALF = 32'h1;
  localparam logic [31:0] DIV_PASS = 32'h0;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_DECIDE, S_CTRL, S_WAIT, S_CHECK} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx;
  rate_entry_t      rom_e;
  rate_entry_t      hit_e;
  logic             hit;
  logic             is_query;
  logic [MHZ_W-1:0] tgt;
  logic [MHZ_W-1:0] best;
  logic             tmr_start;
  logic             tmr_fire;

  clk_rate_rom u_rom (.idx(idx), .entry(rom_e));

  clk_lock_timer #(.CYCLES(LOCK_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .fire(tmr_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      idx       <= '0;
      hit_e     <= '0;
      hit       <= 1'b0;
      is_query  <= 1'b0;
      tgt       <= '0;
      best      <= '0;
      tmr_start <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      status    <= RES_OK;
      resp_mhz  <= '0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      done      <= 1'b0;
      bus_wr    <= 1'b0;
      tmr_start <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          tgt      <= req_mhz;
          is_query <= req_query;
          idx      <= '0;
          hit      <= 1'b0;
          busy     <= 1'b1;
          state    <= S_SCAN;
        end
        S_SCAN: begin
          // Earlier entry kept unless a later one is strictly closer.
          if (idx == '0 || abs_diff(tgt, rom_e.mhz) < abs_diff(tgt, best))
            best <= rom_e.mhz;
          if (rom_e.mhz == tgt) begin
            hit   <= 1'b1;
            hit_e <= rom_e;
          end
          if (idx == IDX_W'(N_RATES - 1)) state <= S_DECIDE;
          else                            idx   <= idx + 1'b1;
        end
        S_DECIDE: begin
          if (is_query) begin
            resp_mhz <= best;
            status   <= RES_OK;
            done     <= 1'b1;
            busy     <= 1'b0;
            state    <= S_IDLE;
          end else if (!hit) begin
            status <= RES_BADRATE;
            done   <= 1'b1;
            busy   <= 1'b0;
            state  <= S_IDLE;
          end else if (DIV_EN && hit_e.mhz > THRESH) begin
            bus_wr    <= 1'b1;
            bus_addr  <= DIV_ADDR;
            bus_wdata <= DIV_HALF;
            state     <= S_CTRL;
          end else begin
            bus_wr    <= 1'b1;
            bus_addr  <= CTRL_ADDR;
            bus_wdata <= pack_ctrl(hit_e);
            tmr_start <= 1'b1;
            state     <= S_WAIT;
          end
        end
        S_CTRL: begin
          bus_wr    <= 1'b1;
          bus_addr  <= CTRL_ADDR;
          bus_wdata <= pack_ctrl(hit_e);
          tmr_start <= 1'b1;
          state     <= S_WAIT;
        end
        S_WAIT: if (tmr_fire) state <= S_CHECK;
        S_CHECK: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
          if (!pll_locked)  status <= RES_TIMEOUT;
          else if (pll_err) status <= RES_ERROR;
          else begin
            status <= RES_OK;
            if (DIV_EN && hit_e.mhz <= THRESH) begin
              bus_wr    <= 1'b1;
              bus_addr  <= DIV_ADDR;
              bus_wdata <= DIV_PASS;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_rate_seq_chk.sv
module clk_rate_seq_chk #(
  parameter int                LOCK_CYCLES = 100,
  parameter int                HAS_IF_DIV  = 1,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h00,
  parameter logic [ADDR_W-1:0] DIV_ADDR    = 8'h10
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata
);
  logic [31:0] since;
  logic        armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      armed <= 1'b0;
    end else if (bus_wr && bus_addr == CTRL_ADDR) begin
      since <= 32'd1;
      armed <= 1'b1;
    end else begin
      if (done) armed <= 1'b0;
      if (since != 32'hFFFF_FFFF) since <= since + 1'b1;
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  assert_wr_in_seq_R8: assert property (@(posedge clk) disable iff (rst) bus_wr |-> (busy || done));
  assert_ctrl_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == CTRL_ADDR) |-> (bus_wdata[1:0] == 2'b00));
  assert_div_code_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == DIV_ADDR) |-> (bus_wdata[31:1] == 31'd0));
  assert_lock_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (done && armed) |-> (since >= 32'(LOCK_CYCLES)));
  assert_no_div_R10: assert property (@(posedge clk) disable iff (rst)
    (HAS_IF_DIV == 0 && bus_wr) |-> (bus_addr != DIV_ADDR));
endmodule

bind clk_rate_seq clk_rate_seq_chk #(
  .LOCK_CYCLES(CLK_MHZ * LOCK_US),
  .HAS_IF_DIV(HAS_IF_DIV),
  .ADDR_W(ADDR_W),
  .CTRL_ADDR(CTRL_ADDR),
  .DIV_ADDR(DIV_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/clk_rate_seq_bench.sv
module clk_rate_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_US    = 20;
  localparam int LOCK_CYC   = LOCK_US;   // CLK_MHZ = 1
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_DIV  = 8'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_query = 1'b0;
  logic [15:0] req_mhz = '0;
  logic pll_locked = 1'b1, pll_err = 1'b0;
  logic busy, done, bus_wr;
  logic [1:0] status;
  logic [15:0] resp_mhz;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata;

  logic n_valid = 1'b0;
  logic [15:0] n_mhz = '0;
  logic n_busy, n_done, n_wr;
  logic [1:0] n_status;
  logic [15:0] n_resp;
  logic [7:0] n_addr;
  logic [31:0] n_wdata;

  int tests = 0, fails = 0, cyc = 0, ctrl_cyc = 0, n_div_writes = 0, n_ctrl_writes = 0;
  logic [59:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_rate_seq #(.CLK_MHZ(1), .LOCK_US(LOCK_US), .CTRL_ADDR(A_CTRL), .DIV_ADDR(A_DIV)) u_clk_rate_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_query(req_query), .req_mhz(req_mhz),
    .pll_locked(pll_locked), .pll_err(pll_err), .busy(busy), .done(done), .status(status),
    .resp_mhz(resp_mhz), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata));

  clk_rate_seq #(.CLK_MHZ(1), .LOCK_US(LOCK_US), .HAS_IF_DIV(0), .CTRL_ADDR(A_CTRL), .DIV_ADDR(A_DIV)) u_clk_rate_seq_nodiv (
    .clk(clk), .rst(rst), .req_valid(n_valid), .req_query(1'b0), .req_mhz(n_mhz),
    .pll_locked(1'b1), .pll_err(1'b0), .busy(n_busy), .done(n_done), .status(n_status),
    .resp_mhz(n_resp), .bus_wr(n_wr), .bus_addr(n_addr), .bus_wdata(n_wdata));

  function automatic logic [31:0] ctrl_word(input int in_d, input int fb, input int out_d);
    return (32'(fb) << 9) | (32'(in_d) << 4) | (32'(out_d) << 2);
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // kind 0 = bus write, 1 = set result, 2 = query result
  task automatic exp_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    exp_q.push_back({2'd0, a, d, 2'd0, 16'd0}); tag_q.push_back(tag);
  endtask
  task automatic exp_set(input logic [1:0] s, input string tag);
    exp_q.push_back({2'd1, 8'd0, 32'd0, s, 16'd0}); tag_q.push_back(tag);
  endtask
  task automatic exp_qry(input logic [15:0] m, input string tag);
    exp_q.push_back({2'd2, 8'd0, 32'd0, 2'd0, m}); tag_q.push_back(tag);
  endtask

  task automatic send(input bit q, input logic [15:0] m);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_query = q; req_mhz = m;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops expected items as the design produces events.
  always @(negedge clk) begin
    cyc++;
    if (!rst && bus_wr) begin
      if (bus_addr == A_CTRL) ctrl_cyc = cyc;
      if (exp_q.size() == 0) check(1'b0, "R6", "unexpected bus write", {bus_addr, bus_wdata}, 0);
      else begin
        logic [59:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(e[59:58] == 2'd0 && e[57:50] == bus_addr && e[49:18] == bus_wdata, t, "bus write",
              {bus_addr, bus_wdata}, {e[57:50], e[49:18]});
      end
    end
    if (!rst && done) begin
      if (exp_q.size() == 0) check(1'b0, "R8", "unexpected done", status, 0);
      else begin
        logic [59:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (e[59:58] == 2'd2)
          check(status == 2'd0 && resp_mhz == e[15:0], t, "query result", {status, resp_mhz}, e[15:0]);
        else
          check(e[59:58] == 2'd1 && status == e[17:16], t, "set status", status, e[17:16]);
        if (e[59:58] == 2'd1 && e[17:16] != 2'd3)
          check(cyc - ctrl_cyc >= LOCK_CYC, "R4", "lock wait cycles", cyc - ctrl_cyc, LOCK_CYC);
      end
    end
    if (!rst && n_wr) begin
      if (n_addr == A_DIV) n_div_writes++;
      if (n_addr == A_CTRL) n_ctrl_writes++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !bus_wr, "R1", "reset outputs", {busy, done, bus_wr}, 0);

    // R2 R3: above threshold, halve before control word, no pass-through afterwards
    pll_locked = 1; pll_err = 0;
    exp_wr(A_DIV, 32'h1, "R2"); exp_wr(A_CTRL, ctrl_word(1, 29, 0), "R3"); exp_set(2'd0, "R4");
    send(1'b0, 16'd1000);
    // R5: boundary 500 is not above threshold
    exp_wr(A_CTRL, ctrl_word(0, 14, 1), "R3"); exp_wr(A_DIV, 32'h0, "R5"); exp_set(2'd0, "R5");
    send(1'b0, 16'd500);
    // R4: timeout, no restoring write
    pll_locked = 0;
    exp_wr(A_DIV, 32'h1, "R2"); exp_wr(A_CTRL, ctrl_word(0, 17, 1), "R3"); exp_set(2'd1, "R4");
    send(1'b0, 16'd600);
    // R4 R5: lock with error at low rate, no divider write
    pll_locked = 1; pll_err = 1;
    exp_wr(A_CTRL, ctrl_word(0, 11, 3), "R3"); exp_set(2'd2, "R4");
    send(1'b0, 16'd100);
    pll_err = 0;
    // R6: not a table rate
    exp_set(2'd3, "R6");
    send(1'b0, 16'd550);
    // R7 R11: queries
    exp_qry(16'd500, "R7"); send(1'b1, 16'd550);
    exp_qry(16'd100, "R7"); send(1'b1, 16'd0);
    exp_qry(16'd1600, "R11"); send(1'b1, 16'd2000);
    exp_qry(16'd900, "R7"); send(1'b1, 16'd950);
    exp_qry(16'd333, "R11"); send(1'b1, 16'd333);
    exp_qry(16'd133, "R11"); send(1'b1, 16'd140);

    // R8: a request raised while busy is dropped
    exp_wr(A_CTRL, ctrl_word(0, 11, 3), "R8"); exp_wr(A_DIV, 32'h0, "R8"); exp_set(2'd0, "R8");
    @(negedge clk);
    req_valid = 1; req_query = 0; req_mhz = 16'd100;
    @(negedge clk);
    req_valid = 0;
    repeat (30) @(negedge clk);
    check(busy, "R8", "busy during sequence", busy, 1);
    req_valid = 1; req_mhz = 16'd1600;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0 && !busy, "R8", "events outstanding", exp_q.size(), 0);

    // R10: variant without divider
    @(negedge clk); n_valid = 1; n_mhz = 16'd1000;
    @(negedge clk); n_valid = 0;
    while (!n_done) @(negedge clk);
    check(n_status == 2'd0, "R10", "nodiv status", n_status, 0);
    repeat (3) @(negedge clk);
    n_valid = 1; n_mhz = 16'd100;
    @(negedge clk); n_valid = 0;
    while (!n_done) @(negedge clk);
    repeat (3) @(negedge clk);
    check(n_div_writes == 0, "R10", "divider writes", n_div_writes, 0);
    check(n_ctrl_writes == 2, "R10", "control writes", n_ctrl_writes, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule